// File: doc/BRIEF.md
# Exception Pending Status Register

This block is the status-and-control word of a small exception controller. It holds a pending flag for every numbered exception and a short nesting stack of the exceptions being handled. From that registered state it derives a live read value with the following fields:

- the exception currently in service;
- the most urgent exception that is pending and allowed to run;
- a flag for pending peripheral interrupts;
- a bit saying whether a return from the current handler would land back at thread level.

Software can raise or drop the pending state of the periodic timer-tick exception with write-one control bits in the same word. The enclosing core supplies the request lines, enables, priorities and masks. It signals when it starts a handler with a take pulse and a number, and when a handler ends with a return pulse.

Exception 2 is the non-maskable interrupt. Numbers 3 to 6 are faults. Number 15 is the timer tick. Peripheral interrupt lines begin at number 16, so the line index is the exception number minus 16. Numbers 0 and 1 are never pending. The field layout of the read word is fixed because software decodes it.

A smaller priority value is more urgent. When two candidates have equal priority, the lower exception number wins. Status fields are combinational functions of the registered pending and nesting state.

Top module: `exc_status_reg`

## Requirements
- R1: After reset no exception is pending or active: the read word is 0x00000800, meaning only bit 11 (return-to-base) is set.
- R2: A request pulse makes its exception pending from the next cycle. Bits [17:12] report the number of the pending, enabled exception with the smallest priority value, the lower number winning a tie, and 0 when there is none. A pending exception that is disabled is never reported.
- R3: When the base-priority input is nonzero, every exception whose priority value is greater than or equal to it is left out of bits [17:12]. A base-priority of zero masks nothing.
- R4: While the fault mask is high, only exception 2 can appear in bits [17:12]. Exception 2 needs no enable, ignores base-priority and beats every other exception. The primask input has no effect on any bit.
- R5: Bits [8:0] read 0 in thread mode, otherwise the number on top of the nesting stack. A take pulse pushes its number and clears that exception's pending state. A return pulse pops one entry.
- R6: Bit 11 reads 1 when at most one exception is active, and 0 while two or more are nested.
- R7: Bit 22 reads 1 when any exception numbered 16 or above is pending, enabled or not. Exception 2, the faults and the tick exception do not set it.
- R8: Writing a word with bit 25 set (and bit 26 clear) removes the pending state of exception 15. A write with bit 25 clear leaves it unchanged. Bit 25 always reads 0.
- R9: Writing bit 26 set makes exception 15 pending. If bits 25 and 26 are both set, setting wins. Bit 26 always reads 0.
- R10: Bit 23 reads 0 when the debug-state input is low. In debug state it mirrors bit 22. All other unnamed bits read 0, and requests on exceptions 0 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data (bits 25 and 26 are used) |
| reg_rdata | output | 32 | Live read value of the status word |
| exc_req | input | NUM_EXC | Per-exception pending request pulses |
| exc_en | input | NUM_EXC | Per-exception enable |
| exc_prio | input | NUM_EXC*PRIO_W | Per-exception priority, exception i at bits [i*PRIO_W +: PRIO_W] |
| base_pri | input | PRIO_W | Base-priority threshold, 0 means off |
| fault_mask | input | 1 | Blocks everything except exception 2 |
| primask | input | 1 | Global mask, deliberately ignored |
| debug_state | input | 1 | Core is halted in debug |
| take_valid | input | 1 | Core enters handler take_num |
| take_num | input | 6 | Exception number being entered |
| ret_valid | input | 1 | Core leaves the current handler |

## Verification
A corrupted pending bit appears in the pending-vector field or the interrupt flag on the first read after the clock edge that stores it, because the fields are combinational. A slip in the nesting stack pointer or stack contents shows up on the next take or return, as a wrong active number or a wrong return-to-base bit. A mistake in the masking order is only visible when masks, ties and disabled candidates overlap. The directed scenarios therefore stack those conditions deliberately and read the word one cycle after each stimulus.

// File: rtl/exc_status_reg.sv
module exc_status_reg #(
  parameter int NUM_EXC  = 48,
  parameter int PRIO_W   = 3,
  parameter int NEST     = 8,
  parameter int TICK_NUM = 15,
  parameter int NMI_NUM  = 2,
  parameter int IRQ_BASE = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic [NUM_EXC-1:0]        exc_req,
  input  logic [NUM_EXC-1:0]        exc_en,
  input  logic [NUM_EXC*PRIO_W-1:0] exc_prio,
  input  logic [PRIO_W-1:0]         base_pri,
  input  logic                      fault_mask,
  input  logic                      primask,
  input  logic                      debug_state,
  input  logic                      take_valid,
  input  logic [5:0]                take_num,
  input  logic                      ret_valid
);
  localparam int SP_W  = (NEST > 1) ? $clog2(NEST) : 1;
  localparam int CNT_W = $clog2(NEST + 1);

  logic [NUM_EXC-1:0] pend, pend_nx, elig;
  logic [5:0]         stk [NEST];
  logic [CNT_W-1:0]   cnt;
  logic [5:0]         cur_num, vec;
  logic               tick_set, tick_clr, take_ok, ret_ok, isr_pend, ret_base;
  logic [PRIO_W-1:0]  best_pri;
  logic               found;

  logic unused_inputs;
  assign unused_inputs = primask ^ (^reg_wdata[24:0]) ^ (^reg_wdata[31:27]);

  assign tick_set = reg_wr & reg_wdata[26];
  assign tick_clr = reg_wr & reg_wdata[25];
  assign take_ok  = take_valid && (cnt < CNT_W'(NEST)) && (int'(take_num) < NUM_EXC);
  assign ret_ok   = ret_valid && !take_valid && (cnt != '0);

  always_comb begin
    pend_nx = pend;
    if (take_ok) pend_nx[take_num] = 1'b0;
    if (tick_clr && !tick_set) pend_nx[TICK_NUM] = 1'b0;
    pend_nx = pend_nx | exc_req;
    if (tick_set) pend_nx[TICK_NUM] = 1'b1;
    pend_nx[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      cnt  <= '0;
    end else begin
      pend <= pend_nx;
      if (take_ok) begin
        stk[cnt[SP_W-1:0]] <= take_num;
        cnt <= cnt + 1'b1;
      end else if (ret_ok) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_EXC; i++) begin
      elig[i] = pend[i] && exc_en[i] && !fault_mask &&
                !((base_pri != '0) && (exc_prio[i*PRIO_W +: PRIO_W] >= base_pri));
    end
    elig[NMI_NUM] = pend[NMI_NUM];
  end

  always_comb begin
    vec      = '0;
    best_pri = '1;
    found    = 1'b0;
    for (int i = NUM_EXC - 1; i >= 2; i--) begin
      if (i != NMI_NUM && elig[i] &&
          (!found || exc_prio[i*PRIO_W +: PRIO_W] <= best_pri)) begin
        found    = 1'b1;
        best_pri = exc_prio[i*PRIO_W +: PRIO_W];
        vec      = 6'(i);
      end
    end
    if (elig[NMI_NUM]) vec = 6'(NMI_NUM);
  end

  assign cur_num  = (cnt == '0) ? 6'd0 : stk[SP_W'(cnt - 1'b1)];
  assign ret_base = (cnt <= CNT_W'(1));
  assign isr_pend = |pend[NUM_EXC-1:IRQ_BASE];

  assign reg_rdata = {5'b0, 2'b00, 1'b0, debug_state & isr_pend, isr_pend,
                      4'b0, vec, ret_base, 2'b00, 3'b000, cur_num};
endmodule

module exc_status_reg_chk #(
  parameter int NUM_EXC  = 48,
  parameter int TICK_NUM = 15,
  parameter int NMI_NUM  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [31:0]        reg_rdata,
  input logic               reg_wr,
  input logic [31:0]        reg_wdata,
  input logic [NUM_EXC-1:0] exc_req,
  input logic [NUM_EXC-1:0] pend,
  input logic               fault_mask,
  input logic               debug_state
);
  assert_dbg_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !debug_state |-> reg_rdata[23] == 1'b0);
  assert_wo_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[26:25] == 2'b00);
  assert_nmi_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_mask && reg_rdata[17:12] != 6'd0) |-> reg_rdata[17:12] == 6'(NMI_NUM));
  assert_vec_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[17:12] != 6'd0) |-> pend[reg_rdata[17:12]]);
  assert_tick_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[25] && !reg_wdata[26] && !exc_req[TICK_NUM]) |=> !pend[TICK_NUM]);
  assert_thread_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[8:0] == 9'd0) |-> reg_rdata[11]);
endmodule

bind exc_status_reg exc_status_reg_chk #(.NUM_EXC(NUM_EXC), .TICK_NUM(TICK_NUM), .NMI_NUM(NMI_NUM)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .exc_req(exc_req), .pend(pend), .fault_mask(fault_mask), .debug_state(debug_state));

// File: tb/exc_status_reg_test.sv
`timescale 1ns/1ps
module exc_status_reg_test;
  localparam int N = 48;
  localparam int PW = 3;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0, rdata;
  logic [N-1:0] exc_req = 0, exc_en = 0;
  logic [N*PW-1:0] exc_prio = 0;
  logic [PW-1:0] base_pri = 0;
  logic fault_mask = 0, primask = 0, debug_state = 0;
  logic take_valid = 0, ret_valid = 0;
  logic [5:0] take_num = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_status_reg uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rdata),
    .exc_req(exc_req), .exc_en(exc_en), .exc_prio(exc_prio), .base_pri(base_pri),
    .fault_mask(fault_mask), .primask(primask), .debug_state(debug_state),
    .take_valid(take_valid), .take_num(take_num), .ret_valid(ret_valid));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; exc_req = 0; exc_en = 0; exc_prio = 0; base_pri = 0;
    fault_mask = 0; primask = 0; debug_state = 0; reg_wr = 0; take_valid = 0; ret_valid = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic set_prio(int n, int p);
    exc_prio[n*PW +: PW] = PW'(p);
  endtask

  task automatic pulse_req(logic [N-1:0] m);
    exc_req = m; @(negedge clk); exc_req = 0;
  endtask

  task automatic wr(logic [31:0] d);
    reg_wr = 1; reg_wdata = d; @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic take(int n);
    take_valid = 1; take_num = 6'(n); @(negedge clk); take_valid = 0;
  endtask

  task automatic ret();
    ret_valid = 1; @(negedge clk); ret_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 reset word", rdata, 32'h0000_0800);
  endtask

  task automatic t_priority();
    do_reset();
    exc_en[20] = 1; exc_en[21] = 1; exc_en[30] = 1;
    set_prio(20, 5); set_prio(21, 3); set_prio(30, 3); set_prio(17, 0);
    pulse_req((N'(1) << 20) | (N'(1) << 21) | (N'(1) << 30) | (N'(1) << 17));
    chk("R2 tie lower number wins, disabled skipped", 32'(rdata[17:12]), 21);
    chk("R7 irq pending flag", 32'(rdata[22]), 1);
    chk("R10 debug bit low outside debug", 32'(rdata[23]), 0);
    debug_state = 1; #0.1;
    chk("R10 debug bit mirrors in debug", 32'(rdata[23]), 1);
    debug_state = 0;
    base_pri = 3; #0.1;
    chk("R3 base masks >= threshold", 32'(rdata[17:12]), 0);
    base_pri = 6; #0.1;
    chk("R3 base 6 passes prio 3", 32'(rdata[17:12]), 21);
    base_pri = 0; set_prio(30, 1); #0.1;
    chk("R2 lowest prio value wins", 32'(rdata[17:12]), 30);
    primask = 1; #0.1;
    chk("R4 primask ignored", 32'(rdata[17:12]), 30);
  endtask

  task automatic t_fault();
    do_reset();
    exc_en[20] = 1; set_prio(20, 0);
    pulse_req(N'(1) << 20);
    fault_mask = 1; #0.1;
    chk("R4 fault mask blocks irq", 32'(rdata[17:12]), 0);
    pulse_req(N'(1) << 2);
    chk("R4 nmi passes fault mask", 32'(rdata[17:12]), 2);
    fault_mask = 0; base_pri = 1; #0.1;
    chk("R4 nmi beats prio 0 and base", 32'(rdata[17:12]), 2);
    chk("R7 flag still from irq 20", 32'(rdata[22]), 1);
  endtask

  task automatic t_active();
    do_reset();
    exc_en[21] = 1; exc_en[30] = 1; set_prio(21, 1); set_prio(30, 2);
    pulse_req((N'(1) << 21) | (N'(1) << 30));
    take(21);
    chk("R5 active after take", 32'(rdata[8:0]), 21);
    chk("R5 taken cleared from pending", 32'(rdata[17:12]), 30);
    chk("R6 one active is base", 32'(rdata[11]), 1);
    take(30);
    chk("R5 nested active", 32'(rdata[8:0]), 30);
    chk("R6 nested not base", 32'(rdata[11]), 0);
    ret();
    chk("R5 pop to outer", 32'(rdata[8:0]), 21);
    chk("R6 base again", 32'(rdata[11]), 1);
    ret();
    chk("R5 thread mode", rdata, 32'h0000_0800);
  endtask

  task automatic t_irq_flag();
    do_reset();
    pulse_req(N'(1) << 4);
    chk("R7 fault not counted", 32'(rdata[22]), 0);
    pulse_req(N'(1) << 16);
    chk("R7 disabled irq counted", 32'(rdata[22]), 1);
    chk("R2 disabled irq not reported", 32'(rdata[17:12]), 0);
  endtask

  task automatic t_tick();
    do_reset();
    exc_en[15] = 1; set_prio(15, 2);
    wr(32'h0400_0000);
    chk("R9 tick set", 32'(rdata[17:12]), 15);
    chk("R7 tick not counted", 32'(rdata[22]), 0);
    wr(32'h0000_0000);
    chk("R8 zero write no effect", 32'(rdata[17:12]), 15);
    wr(32'h0200_0000);
    chk("R8 tick cleared", 32'(rdata[17:12]), 0);
    wr(32'h0600_0000);
    chk("R9 set wins over clear", 32'(rdata[17:12]), 15);
    chk("R8 R9 control bits read 0", 32'(rdata[26:25]), 0);
  endtask

  task automatic t_low();
    do_reset();
    exc_en[1:0] = 2'b11;
    pulse_req(N'(3));
    chk("R10 exceptions 0 and 1 ignored", rdata, 32'h0000_0800);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_fault();
    t_active();
    t_irq_flag();
    t_tick();
    t_low();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule